// File: doc/BRIEF.md
# Effective Address Generator

This block forms the 32-bit effective address used by load, store and branch operations. It adds a base operand to either a sign-extended 16-bit immediate or a second register value; a mode input picks which one. The base comes from a register value supplied by the caller. When the accompanying base-register index is zero, the block uses a literal zero in its place. The addition is unsigned and wraps modulo 2^32. Any carry out of the top bit is dropped.

The result is registered, so the address appears one clock after a valid request. It comes with two qualifiers for the operand size of that request. A wrap flag marks an operand whose bytes run past the highest address and continue at address zero. A misalignment flag marks an address that is not a multiple of the operand length. Register-file reads, translation and exception handling belong to the surrounding pipeline.

Top module: `ea_gen`

## Requirements
- R1: While reset (`rstN` low) is applied and on the first cycle after it, `outValid`, `wrapFlag` and `misalignFlag` are 0 and `effAddr` is 0.
- R2: With `addrMode` = 0 (immediate mode), the address is the base plus the 16-bit `immOffset` sign-extended to 32 bits, modulo 2^32. An offset of zero yields the base itself.
- R3: With `addrMode` = 1 (index mode), the address is the base plus `indexVal`, modulo 2^32. A carry out of bit 31 is discarded.
- R4: When `baseSel` equals 0, the base is the constant 0 regardless of `baseVal`, in both modes.
- R5: `outValid` equals `inValid` delayed by exactly one clock. The address and flags for a request accepted at one rising edge are visible after that edge.
- R6: `sizeCode` gives an operand length of 2^sizeCode bytes: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 8 bytes. `wrapFlag` is 1 exactly when address + length > 2^32. A 1-byte operand therefore never wraps.
- R7: `misalignFlag` is 1 exactly when the address modulo the operand length is nonzero. A 1-byte operand is never misaligned.
- R8: On a cycle with `inValid` low, `effAddr`, `wrapFlag` and `misalignFlag` keep the values they held before that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| inValid | input | 1 | Request present this cycle |
| addrMode | input | 1 | 0 selects base plus immediate, 1 selects base plus index |
| baseSel | input | 5 | Base register index; zero forces a zero base |
| baseVal | input | 32 | Base register contents |
| immOffset | input | 16 | Signed immediate displacement |
| indexVal | input | 32 | Index register contents |
| sizeCode | input | 2 | Operand length code, length = 2^sizeCode bytes |
| outValid | output | 1 | Result valid, one cycle after inValid |
| effAddr | output | 32 | Registered effective address |
| wrapFlag | output | 1 | Operand crosses the top of the address space |
| misalignFlag | output | 1 | Address not a multiple of operand length |

## Verification
The assertions assume that every input is a known value on each rising edge once reset is released. They also assume that `sizeCode` and `addrMode` are sampled together with `inValid`, so they relate a registered output only to the request captured one edge earlier. The stimulus honours this in two ways. It drives every input on the falling edge, so each value is stable around the capturing rising edge. It also drives all inputs to defined values from time zero, including during idle cycles when `inValid` is low.

// File: rtl/ea_gen_pkg.sv
package ea_gen_pkg;
  localparam int ADDR_W = 32;
  localparam int IMM_W  = 16;
  localparam int SEL_W  = 5;
  localparam int SIZE_W = 2;
  // widest operand is 2**(2**SIZE_W-1) bytes; its offset mask needs this many bits
  localparam int MASK_W = (2 ** SIZE_W) - 1;

  typedef enum logic {
    MODE_IMM = 1'b0,
    MODE_IDX = 1'b1
  } addrMode_e;

  typedef struct packed {
    logic              load;      // capture new result
    logic              zeroBase;  // force base to zero
    logic              pickIndex; // second operand is the index register
    logic [MASK_W-1:0] lenMask;   // operand length minus one
  } ctlStrobes_t;
endpackage

// File: rtl/ea_gen_ctrl.sv
module ea_gen_ctrl
  import ea_gen_pkg::*;
#(
  parameter int SelW  = SEL_W,
  parameter int SizeW = SIZE_W,
  parameter int MaskW = MASK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             addrMode,
  input  logic [SelW-1:0]  baseSel,
  input  logic [SizeW-1:0] sizeCode,
  output ctlStrobes_t      strobes,
  output logic             validQ
);
  logic [MaskW-1:0] maskComb;

  // thermometer mask: bits below the size code are ones
  always_comb begin
    for (int i = 0; i < MaskW; i++) begin
      maskComb[i] = (i < int'(sizeCode));
    end
  end

  always_comb begin
    strobes.load      = inValid;
    strobes.zeroBase  = (baseSel == '0);
    strobes.pickIndex = (addrMode_e'(addrMode) == MODE_IDX);
    strobes.lenMask   = maskComb;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end
endmodule

// File: rtl/ea_gen_dpath.sv
module ea_gen_dpath
  import ea_gen_pkg::*;
#(
  parameter int AddrW = ADDR_W,
  parameter int ImmW  = IMM_W,
  parameter int MaskW = MASK_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strobes,
  input  logic [AddrW-1:0] baseVal,
  input  logic [ImmW-1:0]  immOffset,
  input  logic [AddrW-1:0] indexVal,
  output logic [AddrW-1:0] addrQ,
  output logic             wrapQ,
  output logic             misalignQ
);
  localparam int ExtW = AddrW - ImmW;

  logic [AddrW-1:0] baseOp;
  logic [AddrW-1:0] immExt;
  logic [AddrW-1:0] secondOp;
  logic [AddrW-1:0] sumComb;
  logic [AddrW:0]   lastByte;
  logic             wrapComb;
  logic             misComb;

  assign baseOp   = strobes.zeroBase ? '0 : baseVal;
  assign immExt   = {{ExtW{immOffset[ImmW-1]}}, immOffset};
  assign secondOp = strobes.pickIndex ? indexVal : immExt;
  // modulo 2^AddrW: carry out is simply not kept
  assign sumComb  = baseOp + secondOp;
  // address of the operand's last byte; bit AddrW set means it passed the top
  assign lastByte = {1'b0, sumComb} + {{(AddrW + 1 - MaskW){1'b0}}, strobes.lenMask};
  assign wrapComb = lastByte[AddrW];
  assign misComb  = |(sumComb[MaskW-1:0] & strobes.lenMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ     <= '0;
      wrapQ     <= 1'b0;
      misalignQ <= 1'b0;
    end else if (strobes.load) begin
      addrQ     <= sumComb;
      wrapQ     <= wrapComb;
      misalignQ <= misComb;
    end
  end
endmodule

// File: rtl/ea_gen.sv
module ea_gen
  import ea_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic              addrMode,
  input  logic [SEL_W-1:0]  baseSel,
  input  logic [ADDR_W-1:0] baseVal,
  input  logic [IMM_W-1:0]  immOffset,
  input  logic [ADDR_W-1:0] indexVal,
  input  logic [SIZE_W-1:0] sizeCode,
  output logic              outValid,
  output logic [ADDR_W-1:0] effAddr,
  output logic              wrapFlag,
  output logic              misalignFlag
);
  ctlStrobes_t strobes;

  ea_gen_ctrl #(.SelW(SEL_W), .SizeW(SIZE_W), .MaskW(MASK_W)) ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .addrMode (addrMode),
    .baseSel  (baseSel),
    .sizeCode (sizeCode),
    .strobes  (strobes),
    .validQ   (outValid)
  );

  ea_gen_dpath #(.AddrW(ADDR_W), .ImmW(IMM_W), .MaskW(MASK_W)) dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .baseVal   (baseVal),
    .immOffset (immOffset),
    .indexVal  (indexVal),
    .addrQ     (effAddr),
    .wrapQ     (wrapFlag),
    .misalignQ (misalignFlag)
  );
endmodule

// File: rtl/ea_gen_checker.sv
module ea_gen_checker
  import ea_gen_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              addrMode,
  input logic [SEL_W-1:0]  baseSel,
  input logic [ADDR_W-1:0] baseVal,
  input logic [IMM_W-1:0]  immOffset,
  input logic [ADDR_W-1:0] indexVal,
  input logic [SIZE_W-1:0] sizeCode,
  input logic              outValid,
  input logic [ADDR_W-1:0] effAddr,
  input logic              wrapFlag,
  input logic              misalignFlag
);
  // R1: first cycle after reset shows a cleared output
  a_r1_reset_clear: assert property (@(posedge clk)
    !rstN |=> (!outValid && effAddr == '0 && !wrapFlag && !misalignFlag));

  // R5: valid is the input valid one clock later
  a_r5_valid_delay: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> (outValid == $past(inValid)));

  // R8: idle cycles leave the result untouched
  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && !inValid) |=> ($stable(effAddr) && $stable(wrapFlag) && $stable(misalignFlag)));

  // R6: a single byte never wraps
  a_r6_byte_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && sizeCode == '0) |=> !wrapFlag);

  // R7: a single byte is never misaligned
  a_r7_byte_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && sizeCode == '0) |=> !misalignFlag);

  // R4, R2: zero base with immediate mode returns the extended offset alone
  a_r4_zero_base_imm: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && baseSel == '0 && addrMode == 1'b0) |=>
      (effAddr == {{(ADDR_W-IMM_W){$past(immOffset[IMM_W-1])}}, $past(immOffset)}));

  // R4, R3: zero base with index mode returns the index alone
  a_r4_zero_base_idx: assert property (@(posedge clk) disable iff (!rstN)
    (rstN && inValid && baseSel == '0 && addrMode == 1'b1) |=> (effAddr == $past(indexVal)));

  // R6: 8-byte operand at an address above the last 8 bytes must wrap
  a_r6_top_wraps: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && effAddr > 32'hFFFF_FFF8 && $past(sizeCode) == 2'd3) |-> wrapFlag);
endmodule

bind ea_gen ea_gen_checker chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .addrMode     (addrMode),
  .baseSel      (baseSel),
  .baseVal      (baseVal),
  .immOffset    (immOffset),
  .indexVal     (indexVal),
  .sizeCode     (sizeCode),
  .outValid     (outValid),
  .effAddr      (effAddr),
  .wrapFlag     (wrapFlag),
  .misalignFlag (misalignFlag)
);

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        addrMode = 1'b0;
  logic [4:0]  baseSel = '0;
  logic [31:0] baseVal = '0;
  logic [15:0] immOffset = '0;
  logic [31:0] indexVal = '0;
  logic [1:0]  sizeCode = '0;
  logic        outValid;
  logic [31:0] effAddr;
  logic        wrapFlag;
  logic        misalignFlag;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .addrMode(addrMode),
    .baseSel(baseSel), .baseVal(baseVal), .immOffset(immOffset),
    .indexVal(indexVal), .sizeCode(sizeCode), .outValid(outValid),
    .effAddr(effAddr), .wrapFlag(wrapFlag), .misalignFlag(misalignFlag)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected values straight from the requirements
  function automatic logic [31:0] refAddr(input logic mode, input logic [4:0] sel,
      input logic [31:0] b, input logic [15:0] imm, input logic [31:0] idx);
    longint base = (sel == 0) ? 0 : longint'(b);
    longint off  = mode ? longint'(idx) : longint'($signed(imm));
    return 32'((base + off) & 64'hFFFF_FFFF);
  endfunction

  // drive one request at the falling edge, check after the capturing edge
  task automatic issue(input string req, input logic mode, input logic [4:0] sel,
      input logic [31:0] b, input logic [15:0] imm, input logic [31:0] idx,
      input logic [1:0] sz);
    logic [31:0] ea;
    longint len;
    @(negedge clk);
    inValid = 1; addrMode = mode; baseSel = sel; baseVal = b;
    immOffset = imm; indexVal = idx; sizeCode = sz;
    @(negedge clk);
    inValid = 0;
    ea  = refAddr(mode, sel, b, imm, idx);
    len = longint'(1) << sz;
    check("R5", "outValid", 32'(outValid), 32'd1);
    check(req, "effAddr", effAddr, ea);
    check("R6", "wrapFlag", 32'(wrapFlag), 32'((longint'(ea) + len) > 64'h1_0000_0000));
    check("R7", "misalignFlag", 32'(misalignFlag), 32'((longint'(ea) % len) != 0));
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "outValid", 32'(outValid), 0);
    check("R1", "effAddr", effAddr, 0);
    check("R1", "wrapFlag", 32'(wrapFlag), 0);
    check("R1", "misalignFlag", 32'(misalignFlag), 0);
  endtask

  task automatic t_immediate();
    issue("R2", 0, 5'd3, 32'h0000_1000, 16'h0010, 32'h0, 2'd2);
    issue("R2", 0, 5'd3, 32'h0000_1000, 16'hFFF0, 32'h0, 2'd2);   // negative
    issue("R2", 0, 5'd7, 32'h8000_0004, 16'h0000, 32'h0, 2'd3);   // zero offset
    issue("R2", 0, 5'd1, 32'h0000_0004, 16'h8000, 32'h0, 2'd0);   // borrow past 0
  endtask

  task automatic t_index();
    issue("R3", 1, 5'd9, 32'h1234_0000, 16'h0, 32'h0000_5678, 2'd1);
    issue("R3", 1, 5'd9, 32'hF000_0000, 16'h0, 32'h2000_0010, 2'd2); // carry dropped
  endtask

  task automatic t_zero_base();
    issue("R4", 0, 5'd0, 32'hDEAD_BEEF, 16'h0040, 32'h0, 2'd2);
    issue("R4", 1, 5'd0, 32'hDEAD_BEEF, 16'h0, 32'h0000_0101, 2'd0);
  endtask

  task automatic t_wrap_edges();
    issue("R6", 1, 5'd2, 32'hFFFF_FFFC, 16'h0, 32'h0, 2'd2); // ends at top, no wrap
    issue("R6", 1, 5'd2, 32'hFFFF_FFFC, 16'h0, 32'h0, 2'd3); // 8 bytes wraps
    issue("R6", 1, 5'd2, 32'hFFFF_FFFF, 16'h0, 32'h0, 2'd0); // byte never wraps
    issue("R6", 1, 5'd2, 32'hFFFF_FFFF, 16'h0, 32'h0, 2'd1);
  endtask

  task automatic t_misalign();
    issue("R7", 1, 5'd4, 32'h0000_0100, 16'h0, 32'h6, 2'd3);
    issue("R7", 1, 5'd4, 32'h0000_0100, 16'h0, 32'h6, 2'd1);
    issue("R7", 1, 5'd4, 32'h0000_0100, 16'h0, 32'h3, 2'd0);
  endtask

  task automatic t_hold();
    logic [31:0] prevAddr;
    logic prevWrap, prevMis;
    issue("R8", 1, 5'd5, 32'hFFFF_FFF9, 16'h0, 32'h0, 2'd2);
    prevAddr = effAddr; prevWrap = wrapFlag; prevMis = misalignFlag;
    @(negedge clk);
    inValid = 0; addrMode = 0; baseSel = 5'd6; baseVal = 32'h0000_0040;
    immOffset = 16'h0; sizeCode = 2'd0;
    @(negedge clk);
    check("R8", "outValid idle", 32'(outValid), 0);
    check("R8", "effAddr held", effAddr, prevAddr);
    check("R8", "wrapFlag held", 32'(wrapFlag), 32'(prevWrap));
    check("R8", "misalignFlag held", 32'(misalignFlag), 32'(prevMis));
  endtask

  task automatic t_stream();
    // back-to-back requests: each result lands one edge after its request
    @(negedge clk);
    inValid = 1; addrMode = 1; baseSel = 5'd8; baseVal = 32'h100; indexVal = 32'h4; sizeCode = 2'd2;
    @(negedge clk);
    check("R5", "stream first", effAddr, 32'h104);
    check("R5", "stream valid", 32'(outValid), 1);
    indexVal = 32'h8;
    @(negedge clk);
    check("R5", "stream second", effAddr, 32'h108);
    inValid = 0;
    @(negedge clk);
    check("R5", "stream drop", 32'(outValid), 0);
  endtask

  initial begin
    #20000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1;
    t_reset();
    t_immediate();
    t_index();
    t_zero_base();
    t_wrap_edges();
    t_misalign();
    t_hold();
    t_stream();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule